// File: doc/BRIEF.md
# Backlight PWM Generator with Byte Register Port

This block drives a display backlight from a single pulse-width-modulated output. Software reaches it through a byte-wide port that carries an address, write data, a write strobe and combinational read data. Three registers sit on this port. The divider register holds the output enable in its top bit and a seven-bit prescale field below it. The duty register holds an eight-bit brightness level. The backlight register holds a bit that drives a separate enable pin for the panel supply.

A prescaler divides the base clock by the programmed amount. Each divided tick advances an eight-bit period counter, so one PWM period spans 256 ticks. The output is high while the counter is below the active duty level, and a level of 255 keeps it high for the whole period. A duty value written while the generator runs is applied only when the counter wraps, so the output never shows a cut-short pulse. Clearing the enable holds both counters at zero and forces the output low. Software can therefore change the divisor safely, and the next period starts cleanly from count zero.

Top module: `bl_pwm_gen`

## Requirements
- R1: After a synchronous active-low reset, all three registers read 0, and both `pwm_out` and `bl_en_out` are low.
- R2: The divider register sits at address 0x4B, the duty register at 0x4E and the backlight register at 0x51. Each returns on `rdata` the full byte last written to it.
- R3: A write to any other address changes no register. A read of any other address returns 0.
- R4: Bit 7 of the divider register enables the PWM output. Bits 6:0 hold D-1, where D (1 to 128) is the prescale ratio. One PWM period lasts 256*D clock cycles.
- R5: While bit 7 of the divider register is 0, `pwm_out` is low and the counters are held at zero. A period starts from count zero in the first cycle after the enabling write, so for a nonzero duty the output is high in that cycle.
- R6: For a duty value N below 255, `pwm_out` is high for exactly N*D cycles of each period, with 0 meaning always low. For N = 255 it is high for all 256*D cycles.
- R7: A duty value written while the output is enabled takes effect at the next period boundary. The period in progress completes with the old value.
- R8: `bl_en_out` follows bit 0 of the backlight register, independently of the PWM enable.
- R9: The divisor can be rewritten while the output is disabled. After it is re-enabled, the period and high time follow the new divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Register byte address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rdata | output | 8 | Read data for `addr` (combinational) |
| pwm_out | output | 1 | PWM waveform |
| bl_en_out | output | 1 | Backlight enable pin |

## Verification
The hardest case to reach is a duty write that arrives in the middle of a running period. It has to be shown that the current period still ends with the old high time and that the next one uses the new value. The stimulus runs an enabled generator and issues the duty write from inside the measuring loop, halfway through the first period. It then counts high cycles period by period and compares them with old*D and new*D. The same loop is used with random divisors and duty values, with a disable, divisor change and re-enable sequence, and with the largest divisor of 128.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
   // register selected by the decoded address
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_DIV  = 2'd1,
      SEL_DUTY = 2'd2,
      SEL_BLEN = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
   import bl_pwm_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter logic [ADDR_W-1:0] DIV_ADDR  = 'h4B,
   parameter logic [ADDR_W-1:0] DUTY_ADDR = 'h4E,
   parameter logic [ADDR_W-1:0] BLEN_ADDR = 'h51
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr_en,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] div_q,
   output logic [DATA_W-1:0] duty_q,
   output logic [DATA_W-1:0] blen_q
);
   reg_sel_e sel;

   always_comb begin
      if (addr == DIV_ADDR)       sel = SEL_DIV;
      else if (addr == DUTY_ADDR) sel = SEL_DUTY;
      else if (addr == BLEN_ADDR) sel = SEL_BLEN;
      else                        sel = SEL_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q  <= '0;
         duty_q <= '0;
         blen_q <= '0;
      end else if (wr_en) begin
         case (sel)
            SEL_DIV:  div_q  <= wdata;
            SEL_DUTY: duty_q <= wdata;
            SEL_BLEN: blen_q <= wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (sel)
         SEL_DIV:  rdata = div_q;
         SEL_DUTY: rdata = duty_q;
         SEL_BLEN: rdata = blen_q;
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/bl_pwm_presc.sv
module bl_pwm_presc #(
   parameter int unsigned DIV_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div_sel,
   output logic             tick,
   output logic [DIV_W-1:0] cnt_o
);
   logic [DIV_W-1:0] cnt;

   // one tick every div_sel+1 cycles while running
   assign tick  = run && (cnt == div_sel);
   assign cnt_o = cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) cnt <= '0;
      else if (tick)      cnt <= '0;
      else                cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core #(
   parameter int unsigned CNT_W   = 8,
   parameter bit          FULL_ON = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] duty_new,
   output logic             pwm,
   output logic [CNT_W-1:0] pc_o,
   output logic [CNT_W-1:0] duty_act_o,
   output logic             wrap_o
);
   localparam logic [CNT_W-1:0] TOP = '1;

   logic [CNT_W-1:0] pc;
   logic [CNT_W-1:0] duty_act;

   assign wrap_o     = run && tick && (pc == TOP);
   assign pc_o       = pc;
   assign duty_act_o = duty_act;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc       <= '0;
         duty_act <= '0;
      end else if (!run) begin
         pc       <= '0;
         duty_act <= duty_new;
      end else if (tick) begin
         pc <= pc + 1'b1;
         if (pc == TOP) duty_act <= duty_new;
      end
   end

   generate
      if (FULL_ON) begin : g_full
         assign pwm = run && ((duty_act == TOP) || (pc < duty_act));
      end else begin : g_plain
         assign pwm = run && (pc < duty_act);
      end
   endgenerate
endmodule

// File: rtl/bl_pwm_gen.sv
module bl_pwm_gen #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned DIV_W     = 7,
   parameter logic [ADDR_W-1:0] DIV_ADDR  = 'h4B,
   parameter logic [ADDR_W-1:0] DUTY_ADDR = 'h4E,
   parameter logic [ADDR_W-1:0] BLEN_ADDR = 'h51,
   parameter bit          FULL_ON   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr_en,
   output logic [DATA_W-1:0] rdata,
   output logic              pwm_out,
   output logic              bl_en_out
);
   localparam int unsigned EN_BIT = DIV_W;
   localparam int unsigned CNT_W  = DATA_W;

   generate
      if (DIV_W + 1 > DATA_W) begin : g_bad_div
         $error("divider field and enable must fit in one register");
      end
      if (DIV_ADDR == DUTY_ADDR || DIV_ADDR == BLEN_ADDR || DUTY_ADDR == BLEN_ADDR) begin : g_bad_map
         $error("register addresses must be distinct");
      end
   endgenerate

   logic [DATA_W-1:0] div_q, duty_q, blen_q;
   logic              run, tick, wrap;
   logic [DIV_W-1:0]  presc_cnt;
   logic [CNT_W-1:0]  pc, duty_act;

   bl_pwm_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .DIV_ADDR(DIV_ADDR), .DUTY_ADDR(DUTY_ADDR), .BLEN_ADDR(BLEN_ADDR)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
      .rdata(rdata), .div_q(div_q), .duty_q(duty_q), .blen_q(blen_q)
   );

   assign run       = div_q[EN_BIT];
   assign bl_en_out = blen_q[0];

   bl_pwm_presc #(.DIV_W(DIV_W)) presc_i (
      .clk(clk), .rst_n(rst_n), .run(run), .div_sel(div_q[DIV_W-1:0]),
      .tick(tick), .cnt_o(presc_cnt)
   );

   bl_pwm_core #(.CNT_W(CNT_W), .FULL_ON(FULL_ON)) core_i (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .duty_new(duty_q),
      .pwm(pwm_out), .pc_o(pc), .duty_act_o(duty_act), .wrap_o(wrap)
   );
endmodule

// File: rtl/bl_pwm_gen_chk.sv
module bl_pwm_gen_chk #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DIV_W  = 7,
   parameter logic [ADDR_W-1:0] DIV_ADDR  = 'h4B,
   parameter logic [ADDR_W-1:0] DUTY_ADDR = 'h4E,
   parameter logic [ADDR_W-1:0] BLEN_ADDR = 'h51
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic              wr_en,
   input logic              pwm_out,
   input logic              bl_en_out,
   input logic [DATA_W-1:0] div_q,
   input logic [DATA_W-1:0] duty_q,
   input logic [DATA_W-1:0] blen_q,
   input logic [DIV_W-1:0]  presc_cnt,
   input logic [DATA_W-1:0] pc,
   input logic [DATA_W-1:0] duty_act,
   input logic              wrap
);
   logic run, unmapped;
   assign run      = div_q[DIV_W];
   assign unmapped = (addr != DIV_ADDR) && (addr != DUTY_ADDR) && (addr != BLEN_ADDR);

   assert_unmapped_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && unmapped) |=> ($stable(div_q) && $stable(duty_q) && $stable(blen_q)));

   assert_off_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !pwm_out);

   assert_held_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !$past(run)) |-> (pc == '0 && presc_cnt == '0));

   assert_full_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && duty_act == '1) |-> pwm_out);

   assert_zero_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && duty_act == '0) |-> !pwm_out);

   assert_defer_duty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !$past(wrap)) |-> $stable(duty_act));

   assert_bl_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == BLEN_ADDR) |=> (bl_en_out == $past(wdata[0])));
endmodule

bind bl_pwm_gen bl_pwm_gen_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W),
   .DIV_ADDR(DIV_ADDR), .DUTY_ADDR(DUTY_ADDR), .BLEN_ADDR(BLEN_ADDR)
) chk_i (
   .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
   .pwm_out(pwm_out), .bl_en_out(bl_en_out), .div_q(div_q), .duty_q(duty_q),
   .blen_q(blen_q), .presc_cnt(presc_cnt), .pc(pc), .duty_act(duty_act),
   .wrap(wrap)
);

// File: tb/bl_pwm_gen_tb_top.sv
module bl_pwm_gen_tb_top;
   localparam logic [7:0] A_DIV = 8'h4B, A_DUTY = 8'h4E, A_BLEN = 8'h51;

   logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
   logic [7:0] addr = 8'h00, wdata = 8'h00, rdata;
   logic       pwm_out, bl_en_out;
   int         total = 0, bad = 0, cyc = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   bl_pwm_gen dut_i (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
      .rdata(rdata), .pwm_out(pwm_out), .bl_en_out(bl_en_out)
   );

   function automatic int exp_high(input int duty, input int d);
      return (duty == 255) ? 256 * d : duty * d;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] v);
      @(negedge clk); addr = a; #1; v = rdata;
   endtask

   // Counts high cycles per period starting at the current negedge (index 0).
   // Optionally writes a new duty at sample index wr_idx.
   task automatic measure(input int d, input int nper, input int wr_idx,
                          input int new_duty, input int exp0, input int expn,
                          input string req);
      int hi = 0;
      int per = 0;
      for (int i = 0; i < nper * 256 * d; i++) begin
         if (i != 0) @(negedge clk);
         if (pwm_out) hi++;
         if (i == wr_idx) begin addr = A_DUTY; wdata = 8'(new_duty); wr_en = 1'b1; end
         if (i == wr_idx + 1) wr_en = 1'b0;
         if ((i + 1) % (256 * d) == 0) begin
            check(req, hi, (per == 0) ? exp0 : expn);
            hi = 0; per++;
         end
      end
   endtask

   // Enables with divisor d and duty n; checks first cycle and nper periods.
   task automatic run_case(input int d, input int n, input int nper);
      wr(A_DUTY, 8'(n));
      wr(A_DIV, 8'h80 | 8'(d - 1));
      check("R5 first cycle", int'(pwm_out), (n != 0) ? 1 : 0);
      measure(d, nper, -5, 0, exp_high(n, d), exp_high(n, d), "R4/R6 high count");
      wr(A_DIV, 8'h00);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000 && !done) begin
         bad++; total++;
         $display("FAIL watchdog actual=%0d expected=<190000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(A_DIV, v);  check("R1 div reset", v, 0);
      rd(A_DUTY, v); check("R1 duty reset", v, 0);
      rd(A_BLEN, v); check("R1 blen reset", v, 0);
      check("R1 pwm low", int'(pwm_out), 0);
      check("R1 bl low", int'(bl_en_out), 0);

      // R2 readback, R3 unmapped
      wr(A_DUTY, 8'hA5); wr(A_BLEN, 8'h3C); wr(A_DIV, 8'h5A);
      rd(A_DUTY, v); check("R2 duty readback", v, 8'hA5);
      rd(A_BLEN, v); check("R2 blen readback", v, 8'h3C);
      rd(A_DIV, v);  check("R2 div readback", v, 8'h5A);
      wr(8'h4C, 8'hFF); wr(8'h00, 8'h11); wr(8'h50, 8'h77);
      rd(A_DUTY, v); check("R3 duty untouched", v, 8'hA5);
      rd(A_BLEN, v); check("R3 blen untouched", v, 8'h3C);
      rd(A_DIV, v);  check("R3 div untouched", v, 8'h5A);
      rd(8'h4C, v);  check("R3 unmapped read", v, 0);
      check("R8 bl follows bit0=0", int'(bl_en_out), 0);

      // R8 independent of PWM enable
      wr(A_BLEN, 8'h01);
      check("R8 bl set", int'(bl_en_out), 1);
      wr(A_DIV, 8'h80); wr(A_DIV, 8'h00);
      check("R8 bl kept across pwm enable toggle", int'(bl_en_out), 1);

      // R5 disabled with full duty stays low
      wr(A_DUTY, 8'hFF);
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (pwm_out) begin check("R5 low while disabled", 1, 0); break; end
      end
      check("R5 low while disabled", int'(pwm_out), 0);

      // directed corners
      run_case(1, 0, 1);
      run_case(1, 255, 2);
      run_case(2, 1, 1);
      run_case(3, 254, 1);
      run_case(128, 100, 1);

      // R7 duty change mid-period (D=2, 40 -> 200)
      wr(A_DUTY, 8'd40);
      wr(A_DIV, 8'h81);
      measure(2, 2, 256, 200, 40 * 2, 200 * 2, "R7 deferred duty");
      // R7 change to full scale (D=1, 10 -> 255)
      wr(A_DIV, 8'h00);
      wr(A_DUTY, 8'd10);
      wr(A_DIV, 8'h80);
      measure(1, 2, 100, 255, 10, 256, "R7 deferred to full");

      // R9 divisor change while disabled
      wr(A_DIV, 8'h00);
      wr(A_DIV, 8'h03);
      check("R9 low while divisor rewritten", int'(pwm_out), 0);
      wr(A_DUTY, 8'd77);
      wr(A_DIV, 8'h83);
      check("R9 first cycle", int'(pwm_out), 1);
      measure(4, 1, -5, 0, 77 * 4, 77 * 4, "R9 new divisor high count");
      wr(A_DIV, 8'h00);

      // random
      for (int t = 0; t < 12; t++) begin
         int d = int'($urandom % 4) + 1;
         int n = int'($urandom % 256);
         run_case(d, n, 1);
      end

      wr(A_BLEN, 8'h00);
      check("R8 bl cleared", int'(bl_en_out), 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule